// File: doc/BRIEF.md
# Error Event Mailbox Between Processor Subsystems

This block carries error reports one way, from a control core to a master core. When the control side detects an illegal-instruction trap, an interrupt it does not support, or a mismatch in an interrupt vector address, a small sender posts a message. On one clock edge it writes a command code, loads the payload that belongs to that code, and raises two flag bits. The raised flags drive an interrupt line toward the master, provided the master has enabled it. The master reads the mailbox and acknowledges by clearing the flags.

The sender never waits for the acknowledge. If the previous message is still flagged, a new event is discarded and a drop counter records the loss. A trap or a vector mismatch stops the sender until the master issues a restart pulse.

Each side has its own register port with a 3-bit select and a 32-bit word. Both ports read the same map. Write rights differ per side, as listed in R10.

Top module: `errmb_top`

## Requirements
- R1: After reset, the command, address, write-data, read-data, flag, enable and drop-count registers are all zero, `m_irq` is 0 and `c_halted` is 0.
- R2: A trap event posts command 0xFFFFFFFE, loads `ev_trap_addr` into the address register, sets flag bits 0 and 31 on the same edge, and halts the sender.
- R3: An unsupported-interrupt event posts command 0xFFFFFFFD and loads `ev_unsup_num`, zero-extended, into the write-data register. The sender keeps running.
- R4: A vector-mismatch event posts command 0xFFFFFFFC, leaves the address and write-data registers unchanged, and halts the sender.
- R5: When events arrive together, the order of precedence is trap, then vector mismatch, then unsupported interrupt. The losing events of that cycle have no effect and are not counted.
- R6: An event that arrives while flag bit 0 or flag bit 31 is still set changes no register and adds one to the drop counter. A dropped trap or vector mismatch still halts the sender.
- R7: While halted, the sender ignores all events: nothing is posted and nothing is counted. A one-cycle `m_restart` pulse returns it to running on the next edge.
- R8: `m_irq` is 1 exactly when the enable bit is 1 and some flag bit is set. The enable bit is bit 0 of select 5 and is written by the master.
- R9: A master write to select 4 clears each flag bit whose data bit is 1. All other flag bits are kept.
- R10: The read map on both ports is: 0 command, 1 address, 2 write-data, 3 read-data, 4 flags, 5 enable, 6 drop count, 7 zero. The control side may write selects 0 to 2. The master may write selects 3 to 5. All other writes are ignored.
- R11: A control-side write that arrives on the same edge as a post is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_trap | input | 1 | Illegal-instruction trap event |
| ev_trap_addr | input | 32 | Address where the trap occurred |
| ev_unsup | input | 1 | Unsupported interrupt event |
| ev_unsup_num | input | NUM_W | Number of the unsupported interrupt |
| ev_vmis | input | 1 | Vector address mismatch event |
| c_wr | input | 1 | Control-side write strobe |
| c_sel | input | 3 | Control-side register select |
| c_wdata | input | 32 | Control-side write data |
| c_rdata | output | 32 | Control-side read data |
| m_wr | input | 1 | Master-side write strobe |
| m_sel | input | 3 | Master-side register select |
| m_wdata | input | 32 | Master-side write data |
| m_rdata | output | 32 | Master-side read data |
| m_restart | input | 1 | Master pulse that releases a halted sender |
| m_irq | output | 1 | Interrupt toward the master |
| c_halted | output | 1 | Sender is halted, waiting for a restart |

## Verification
The bench aims at four corner cases:
- **Event arriving before the acknowledge.** A design that queued the message, or overwrote the command, would show a changed command register and an unchanged drop count.
- **Partial acknowledge that clears only bit 0.** A design that tested a single flag bit for pending would post over a half-acknowledged message.
- **All three events on one edge, and events arriving while halted.** A wrong priority posts the wrong command code. A leaky halt gives the drop counter a count it should not have.
- **Writes from the wrong side, and a control write landing on the posting edge.** A design that got these wrong would corrupt the command or payload that the master reads.

// File: rtl/errmb_pkg.sv
package errmb_pkg;
  localparam int REG_W = 32;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {EV_NONE, EV_UNSUP, EV_VMIS, EV_TRAP} ev_kind_t;
  typedef enum logic [0:0] {SND_RUN, SND_HALT} snd_state_t;

  localparam logic [SEL_W-1:0] SEL_CMD  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ADDR = 3'd1;
  localparam logic [SEL_W-1:0] SEL_WDAT = 3'd2;
  localparam logic [SEL_W-1:0] SEL_RDAT = 3'd3;
  localparam logic [SEL_W-1:0] SEL_FLAG = 3'd4;
  localparam logic [SEL_W-1:0] SEL_IEN  = 3'd5;
  localparam logic [SEL_W-1:0] SEL_DROP = 3'd6;

  localparam logic [REG_W-1:0] POST_MASK = {1'b1, {(REG_W-2){1'b0}}, 1'b1};

  // Command word for an event class: all ones minus a class offset.
  function automatic logic [REG_W-1:0] cmd_code(ev_kind_t k);
    case (k)
      EV_TRAP:  cmd_code = ~REG_W'(1);
      EV_UNSUP: cmd_code = ~REG_W'(2);
      EV_VMIS:  cmd_code = ~REG_W'(3);
      default:  cmd_code = '0;
    endcase
  endfunction

  function automatic logic halts_sender(ev_kind_t k);
    halts_sender = (k == EV_TRAP) || (k == EV_VMIS);
  endfunction

  function automatic logic msg_pending(logic [REG_W-1:0] f);
    msg_pending = f[0] | f[REG_W-1];
  endfunction
endpackage

// File: rtl/errmb_arbiter.sv
module errmb_arbiter
  import errmb_pkg::*;
(
  input  logic     trap,
  input  logic     vmis,
  input  logic     unsup,
  output ev_kind_t kind
);
  always_comb begin
    if (trap)       kind = EV_TRAP;
    else if (vmis)  kind = EV_VMIS;
    else if (unsup) kind = EV_UNSUP;
    else            kind = EV_NONE;
  end
endmodule

// File: rtl/errmb_sender.sv
module errmb_sender
  import errmb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ev_kind_t         kind,
  input  logic             pending,
  input  logic             restart,
  output logic             posted,
  output logic             dropped,
  output logic             halted,
  output logic [CNT_W-1:0] drop_cnt
);
  snd_state_t state_q;
  logic       any_ev;

  assign any_ev  = (kind != EV_NONE);
  assign halted  = (state_q == SND_HALT);
  assign posted  = !halted && any_ev && !pending;
  assign dropped = !halted && any_ev && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SND_RUN;
      drop_cnt <= '0;
    end else begin
      case (state_q)
        SND_RUN:  if (any_ev && halts_sender(kind)) state_q <= SND_HALT;
        SND_HALT: if (restart) state_q <= SND_RUN;
        default:  state_q <= SND_RUN;
      endcase
      if (dropped) drop_cnt <= drop_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/errmb_top.sv
module errmb_top
  import errmb_pkg::*;
#(
  parameter int NUM_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_trap,
  input  logic [REG_W-1:0] ev_trap_addr,
  input  logic             ev_unsup,
  input  logic [NUM_W-1:0] ev_unsup_num,
  input  logic             ev_vmis,
  input  logic             c_wr,
  input  logic [SEL_W-1:0] c_sel,
  input  logic [REG_W-1:0] c_wdata,
  output logic [REG_W-1:0] c_rdata,
  input  logic             m_wr,
  input  logic [SEL_W-1:0] m_sel,
  input  logic [REG_W-1:0] m_wdata,
  output logic [REG_W-1:0] m_rdata,
  input  logic             m_restart,
  output logic             m_irq,
  output logic             c_halted
);
  localparam int NPORT = 2;

  ev_kind_t         kind;
  logic             posted, dropped, halted, pending;
  logic [CNT_W-1:0] drop_cnt;
  logic [REG_W-1:0] cmd_q, addr_q, wdat_q, rdat_q, flag_q, ack_mask;
  logic             ien_q;

  errmb_arbiter u_arb (
    .trap(ev_trap), .vmis(ev_vmis), .unsup(ev_unsup), .kind(kind)
  );

  assign pending = msg_pending(flag_q);

  errmb_sender #(.CNT_W(CNT_W)) u_snd (
    .clk(clk), .rst_n(rst_n), .kind(kind), .pending(pending),
    .restart(m_restart), .posted(posted), .dropped(dropped),
    .halted(halted), .drop_cnt(drop_cnt)
  );

  assign ack_mask = (m_wr && m_sel == SEL_FLAG) ? m_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      flag_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (posted) begin
        cmd_q <= cmd_code(kind);
        if (kind == EV_TRAP)  addr_q <= ev_trap_addr;
        if (kind == EV_UNSUP) wdat_q <= REG_W'(ev_unsup_num);
      end else if (c_wr) begin
        case (c_sel)
          SEL_CMD:  cmd_q  <= c_wdata;
          SEL_ADDR: addr_q <= c_wdata;
          SEL_WDAT: wdat_q <= c_wdata;
          default: ;
        endcase
      end
      if (m_wr && m_sel == SEL_RDAT) rdat_q <= m_wdata;
      if (m_wr && m_sel == SEL_IEN)  ien_q  <= m_wdata[0];
      flag_q <= (flag_q & ~ack_mask) | (posted ? POST_MASK : '0);
    end
  end

  assign m_irq    = ien_q && (flag_q != '0);
  assign c_halted = halted;

  // Both ports share one read map.
  logic [SEL_W-1:0] rsel [NPORT];
  logic [REG_W-1:0] rword[NPORT];
  assign rsel[0] = c_sel;
  assign rsel[1] = m_sel;

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_comb begin
      case (rsel[p])
        SEL_CMD:  rword[p] = cmd_q;
        SEL_ADDR: rword[p] = addr_q;
        SEL_WDAT: rword[p] = wdat_q;
        SEL_RDAT: rword[p] = rdat_q;
        SEL_FLAG: rword[p] = flag_q;
        SEL_IEN:  rword[p] = REG_W'(ien_q);
        SEL_DROP: rword[p] = REG_W'(drop_cnt);
        default:  rword[p] = '0;
      endcase
    end
  end

  assign c_rdata = rword[0];
  assign m_rdata = rword[1];
endmodule

// File: rtl/errmb_chk.sv
module errmb_chk
  import errmb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             posted,
  input logic             dropped,
  input logic             halted,
  input logic [REG_W-1:0] flag_q,
  input logic [REG_W-1:0] cmd_q,
  input logic             m_irq,
  input logic             ien_q,
  input logic             m_wr,
  input logic [SEL_W-1:0] m_sel,
  input logic             c_wr,
  input logic             m_restart,
  input logic             ev_trap,
  input logic             ev_vmis,
  input logic             ev_unsup
);
  // R2
  post_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    posted |=> (flag_q[0] && flag_q[REG_W-1]));
  // R2
  trap_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (posted && ev_trap) |=> (halted && cmd_q == 32'hFFFF_FFFE));
  // R4
  vmis_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (posted && ev_vmis && !ev_trap) |=> (halted && cmd_q == 32'hFFFF_FFFC));
  // R3
  unsup_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (posted && ev_unsup && !ev_trap && !ev_vmis) |=> (!halted && cmd_q == 32'hFFFF_FFFD));
  // R6
  no_post_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] || flag_q[REG_W-1]) |-> !posted);
  // R6
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dropped && !c_wr) |=> $stable(cmd_q));
  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !m_restart) |=> halted);
  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!posted && !dropped));
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (posted && ien_q && !(m_wr && m_sel == SEL_IEN)) |=> m_irq);
endmodule

bind errmb_top errmb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .posted(posted), .dropped(dropped),
  .halted(halted), .flag_q(flag_q), .cmd_q(cmd_q), .m_irq(m_irq),
  .ien_q(ien_q), .m_wr(m_wr), .m_sel(m_sel), .c_wr(c_wr),
  .m_restart(m_restart), .ev_trap(ev_trap), .ev_vmis(ev_vmis),
  .ev_unsup(ev_unsup)
);

// File: tb/test_errmb_top.sv
module test_errmb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ev_trap = 0, ev_unsup = 0, ev_vmis = 0;
  logic [31:0] ev_trap_addr = 0;
  logic [7:0]  ev_unsup_num = 0;
  logic        c_wr = 0, m_wr = 0, m_restart = 0;
  logic [2:0]  c_sel = 0, m_sel = 0;
  logic [31:0] c_wdata = 0, m_wdata = 0;
  logic [31:0] c_rdata, m_rdata;
  logic        m_irq, c_halted;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] r_cmd, r_addr, r_wd, r_rd, r_flg;
  bit          r_ien, r_hlt;
  int          r_drop;

  always #10 clk = ~clk;

  errmb_top i_errmb_top (.*);

  function automatic logic [31:0] ref_read(logic [2:0] s);
    case (s)
      0: return r_cmd;
      1: return r_addr;
      2: return r_wd;
      3: return r_rd;
      4: return r_flg;
      5: return {31'd0, r_ien};
      6: return r_drop % 256;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    bit is_trap, is_vmis, any, pend, post, drop, hev;
    logic [31:0] n_cmd, n_addr, n_wd, n_flg;
    @(posedge clk);
    if (!rst_n) begin
      r_cmd = 0; r_addr = 0; r_wd = 0; r_rd = 0; r_flg = 0;
      r_ien = 0; r_hlt = 0; r_drop = 0;
    end else begin
      is_trap = ev_trap;
      is_vmis = !ev_trap && ev_vmis;
      any  = ev_trap || ev_vmis || ev_unsup;
      hev  = ev_trap || ev_vmis;
      pend = r_flg[0] || r_flg[31];
      post = !r_hlt && any && !pend;
      drop = !r_hlt && any && pend;
      n_cmd = r_cmd; n_addr = r_addr; n_wd = r_wd;
      if (post) begin
        if (is_trap) begin n_cmd = 32'hFFFFFFFE; n_addr = ev_trap_addr; end
        else if (is_vmis) n_cmd = 32'hFFFFFFFC;
        else begin n_cmd = 32'hFFFFFFFD; n_wd = {24'd0, ev_unsup_num}; end
      end else if (c_wr) begin
        if (c_sel == 0) n_cmd = c_wdata;
        if (c_sel == 1) n_addr = c_wdata;
        if (c_sel == 2) n_wd = c_wdata;
      end
      n_flg = r_flg;
      if (m_wr && m_sel == 4) n_flg = n_flg & ~m_wdata;
      if (post) n_flg = n_flg | 32'h80000001;
      if (m_wr && m_sel == 3) r_rd = m_wdata;
      if (m_wr && m_sel == 5) r_ien = m_wdata[0];
      if (drop) r_drop++;
      if (r_hlt) r_hlt = !m_restart;
      else r_hlt = any && hev;
      r_cmd = n_cmd; r_addr = n_addr; r_wd = n_wd; r_flg = n_flg;
    end
    @(negedge clk);
    check(tag, "m_irq", {31'd0, m_irq}, {31'd0, r_ien && (r_flg != 0)});
    check(tag, "c_halted", {31'd0, c_halted}, {31'd0, r_hlt});
    check(tag, "c_rdata", c_rdata, ref_read(c_sel));
    check(tag, "m_rdata", m_rdata, ref_read(m_sel));
    ev_trap = 0; ev_unsup = 0; ev_vmis = 0;
    c_wr = 0; m_wr = 0; m_restart = 0;
  endtask

  task automatic rd_all(string tag);
    for (int s = 0; s < 8; s++) begin
      m_sel = s[2:0]; c_sel = 3'(7 - s);
      step(tag);
    end
  endtask

  task automatic mwrite(logic [2:0] s, logic [31:0] d, string tag);
    m_wr = 1; m_sel = s; m_wdata = d;
    step(tag);
  endtask

  task automatic cwrite(logic [2:0] s, logic [31:0] d, string tag);
    c_wr = 1; c_sel = s; c_wdata = d;
    step(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step("R1"); step("R1");
    rst_n = 1;
    rd_all("R1");
    mwrite(5, 1, "R8");
    // unsupported interrupt
    ev_unsup = 1; ev_unsup_num = 8'h2A; step("R3");
    rd_all("R3");
    // arrivals while pending are dropped
    ev_unsup = 1; ev_unsup_num = 8'h55; step("R6");
    ev_trap = 1; ev_trap_addr = 32'h1234_5678; step("R6");
    rd_all("R6");
    m_restart = 1; step("R7");
    // partial acknowledge keeps bit 31 pending
    mwrite(4, 32'h1, "R9");
    ev_unsup = 1; ev_unsup_num = 8'h11; step("R9");
    rd_all("R9");
    mwrite(4, 32'h8000_0000, "R9");
    rd_all("R9");
    // simultaneous events: trap wins
    ev_trap = 1; ev_vmis = 1; ev_unsup = 1;
    ev_trap_addr = 32'hCAFE_0040; ev_unsup_num = 8'h77; step("R5");
    rd_all("R5");
    mwrite(4, 32'hFFFF_FFFF, "R9");
    ev_unsup = 1; step("R7");
    ev_vmis = 1; step("R7");
    rd_all("R7");
    m_restart = 1; step("R7");
    // vector mismatch beats unsupported
    ev_vmis = 1; ev_unsup = 1; ev_unsup_num = 8'h99; step("R5");
    rd_all("R4");
    mwrite(5, 0, "R8");
    step("R8");
    mwrite(5, 1, "R8");
    mwrite(4, 32'h8000_0001, "R9");
    m_restart = 1; step("R7");
    // access rights
    mwrite(0, 32'hDEAD_BEEF, "R10");
    mwrite(1, 32'hDEAD_BEEF, "R10");
    mwrite(6, 32'hDEAD_BEEF, "R10");
    cwrite(0, 32'h0000_1111, "R10");
    cwrite(1, 32'h0000_2222, "R10");
    cwrite(2, 32'h0000_3333, "R10");
    cwrite(3, 32'h0000_4444, "R10");
    cwrite(4, 32'hFFFF_FFFF, "R10");
    cwrite(5, 32'h0, "R10");
    mwrite(3, 32'h5A5A_A5A5, "R10");
    rd_all("R10");
    // control write on a posting edge
    c_wr = 1; c_sel = 0; c_wdata = 32'h0BAD_0BAD;
    ev_unsup = 1; ev_unsup_num = 8'h3C; step("R11");
    rd_all("R11");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule